// File: doc/BRIEF.md
# Dual-Bank Edge/Level Interrupt Controller

This block collects 64 interrupt source lines in two banks of 32 and presents them to a processor through a small word-addressed register port. Every source line first passes through a two-stage synchronizer. Most sources are edge-type: a rising edge on the synchronized line sets a sticky event bit, and software clears that bit by writing a one to the bank's acknowledge register. A fixed, hard-wired group of sources is level-type: these bits never latch an event, and they are pending for as long as their synchronized line stays high.

Each bank holds an enable register. A source is pending when it is enabled and either its event bit is set or, for a level-type source, its line is high. The block drives one registered interrupt request, which is the OR of all pending sources. Beside it, it drives the number of the highest-numbered pending source. The upper bank is searched before the lower bank. The two banks sit at addresses that are not in bank order within a 64-byte window.

Top module: `irq_bank_ctrl`

## Requirements
- R1: The register window is 64 bytes wide and addressed in bytes on 32-bit word boundaries. Each bank holds four words: event at +0x0, enable at +0x4, acknowledge at +0x8 and live line state at +0xC. The bank for sources 0..31 starts at 0x20. The bank for sources 32..63 starts at 0x10. Any other word reads as zero, and a write to it changes nothing.
- R2: When a synchronized rising edge appears on an edge-type source, that source's event bit is set, even if the source is disabled. The event bit does not depend on enable state.
- R3: Writing the acknowledge word clears every event bit whose data bit is 1. Data bits that are 0 leave their event bits untouched. The acknowledge word always reads as zero.
- R4: Reading the enable word returns the value that was last written to it.
- R5: Setting an enable bit while the source line is already high neither sets that source's event bit nor raises a request.
- R6: The live-state word reads as the synchronized state of all 32 lines of the bank. Sources 20..29 of the lower bank (mask 0x3ff00000) are level-type: they never set an event bit, and while enabled they are pending exactly while their line is high. All sources of the upper bank are edge-type.
- R7: The pending set is (event | (live & level mask)) & enable. The request output is 1 in the cycle after any source is pending. It drops in the cycle after no source is pending.
- R8: The index output gives the highest-numbered pending source, 0..63. Pending sources in the upper bank take priority over those in the lower bank. The index-valid output equals the request output, and both are registered together with the index.
- R9: If a rising edge and an acknowledge of the same bit meet in the same cycle, the event bit ends up set.
- R10: Writes to the event word and to the live-state word are ignored.
- R11: A synchronous active-high reset clears every enable and event bit, drops the request output and makes the index invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 64 | Interrupt source lines (bits 31..0 lower bank, 63..32 upper bank) |
| reg_addr | input | 6 | Byte address within the register window |
| reg_wr | input | 1 | Write strobe, sampled on the clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq_o | output | 1 | Combined interrupt request |
| irq_vld_o | output | 1 | Index output is valid |
| irq_idx_o | output | 6 | Highest-numbered pending source |

## Verification
An acknowledge write and a fresh rising edge on the same source can take effect at the same clock edge. To force this, the bench first latches an event on a source and lets the line drop. It then drives the line high again and times the acknowledge write so that the write is captured at exactly the edge where the synchronizer reports the rise, which is the third clock edge after the line changes. Reading the event word afterwards must show the bit still set. A second, plain acknowledge must then clear it, which shows that the first write did reach the bank.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int BANK_W    = 32;
    localparam int N_BANKS   = 2;
    localparam int SRC_W     = BANK_W * N_BANKS;
    localparam int IDX_W     = $clog2(SRC_W);
    localparam int BIT_W     = $clog2(BANK_W);
    localparam int BSEL_W    = (N_BANKS > 1) ? $clog2(N_BANKS) : 1;
    localparam int ADDR_W    = 6;
    localparam int DATA_W    = 32;
    localparam int BANK_SPAN = 16;

    typedef enum logic [1:0] {
        RG_EVT = 2'd0,
        RG_EN  = 2'd1,
        RG_ACK = 2'd2,
        RG_LVL = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic              hit;
        logic [BSEL_W-1:0] bank;
        reg_sel_e          sel;
    } reg_dec_t;

    typedef struct packed {
        logic             irq;
        logic             vld;
        logic [IDX_W-1:0] idx;
    } irq_out_t;

    // Base byte offset of each bank: lower sources sit higher in the window
    function automatic logic [ADDR_W-1:0] bank_base(input int b);
        return ADDR_W'(BANK_SPAN * (N_BANKS - b));
    endfunction

    // Hard-wired level-type sources per bank
    function automatic logic [BANK_W-1:0] level_mask(input int b);
        return (b == 0) ? BANK_W'(32'h3ff0_0000) : '0;
    endfunction

    function automatic reg_dec_t decode(input logic [ADDR_W-1:0] addr);
        reg_dec_t d;
        d.hit  = 1'b0;
        d.bank = '0;
        d.sel  = reg_sel_e'(addr[3:2]);
        for (int b = 0; b < N_BANKS; b++) begin
            if ((addr & ~ADDR_W'(BANK_SPAN - 1)) == bank_base(b)) begin
                d.hit  = 1'b1;
                d.bank = BSEL_W'(b);
            end
        end
        return d;
    endfunction

    // Highest set bit of a bank vector
    function automatic logic [BIT_W-1:0] top_bit(input logic [BANK_W-1:0] v);
        logic [BIT_W-1:0] r;
        r = '0;
        for (int i = 0; i < BANK_W; i++) begin
            if (v[i]) r = BIT_W'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] line_i,
    output logic [W-1:0] live_o,
    output logic [W-1:0] rise_o
);

    logic [W-1:0] meta_q;
    logic [W-1:0] live_q;
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            live_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= line_i;
            live_q <= meta_q;
            prev_q <= live_q;
        end
    end

    assign live_o = live_q;
    assign rise_o = live_q & ~prev_q;

endmodule

// File: rtl/intc_bank.sv
module intc_bank
    import intc_pkg::*;
#(
    parameter int          W        = BANK_W,
    parameter logic [W-1:0] LVL_MASK = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] live_i,
    input  logic [W-1:0] rise_i,
    input  logic         en_wr_i,
    input  logic         ack_wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] evt_o,
    output logic [W-1:0] en_o,
    output logic [W-1:0] pend_o
);

    logic [W-1:0] evt_q;
    logic [W-1:0] en_q;
    logic [W-1:0] clr_mask;
    logic [W-1:0] set_mask;

    assign clr_mask = ack_wr_i ? wdata_i : '0;
    assign set_mask = rise_i & ~LVL_MASK;

    always_ff @(posedge clk) begin
        if (rst) begin
            evt_q <= '0;
            en_q  <= '0;
        end else begin
            evt_q <= (evt_q & ~clr_mask) | set_mask;
            if (en_wr_i) en_q <= wdata_i;
        end
    end

    assign evt_o  = evt_q;
    assign en_o   = en_q;
    assign pend_o = (evt_q | (live_i & LVL_MASK)) & en_q;

    // R2
    edge_latch_chk: assert property (@(posedge clk) disable iff (rst)
        (rise_i & ~LVL_MASK) != '0 |=> (evt_q & $past(rise_i & ~LVL_MASK)) == $past(rise_i & ~LVL_MASK));

    // R3
    ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ack_wr_i |=> (evt_q & $past(wdata_i & ~rise_i)) == '0);

    // R4
    en_readback_chk: assert property (@(posedge clk) disable iff (rst)
        en_wr_i |=> en_q == $past(wdata_i));

    // R5
    no_spurious_evt_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (evt_q & ~$past(evt_q) & ~$past(rise_i)) == '0);

    // R6
    level_no_evt_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (evt_q & LVL_MASK) == '0);

endmodule

// File: rtl/intc_prio.sv
module intc_prio
    import intc_pkg::*;
#(
    parameter int W  = BANK_W,
    parameter int NB = N_BANKS
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NB*W-1:0] pend_i,
    output irq_out_t        out_o
);

    localparam int BW = $clog2(W);
    localparam int IW = $clog2(NB * W);

    logic [NB-1:0]  any_b;
    logic [BW-1:0]  top_b [NB];
    irq_out_t       nxt;

    for (genvar b = 0; b < NB; b++) begin : g_bank
        logic [W-1:0] slice;
        assign slice    = pend_i[b*W +: W];
        assign any_b[b] = |slice;
        assign top_b[b] = top_bit(slice);
    end

    // Upper bank first: scanning upward lets the highest busy bank win
    always_comb begin
        nxt = '0;
        for (int b = 0; b < NB; b++) begin
            if (any_b[b]) begin
                nxt.irq = 1'b1;
                nxt.vld = 1'b1;
                nxt.idx = IW'(b * W) + IW'(top_b[b]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) out_o <= '0;
        else     out_o <= nxt;
    end

endmodule

// File: rtl/irq_bank_ctrl.sv
module irq_bank_ctrl
    import intc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [SRC_W-1:0]  src_i,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_o,
    output logic              irq_vld_o,
    output logic [IDX_W-1:0]  irq_idx_o
);

    reg_dec_t          dec;
    logic [SRC_W-1:0]  live_all;
    logic [SRC_W-1:0]  rise_all;
    logic [SRC_W-1:0]  evt_all;
    logic [SRC_W-1:0]  en_all;
    logic [SRC_W-1:0]  pend_all;
    irq_out_t          prio_q;

    assign dec = decode(reg_addr);

    intc_sync #(.W(SRC_W)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .line_i (src_i),
        .live_o (live_all),
        .rise_o (rise_all)
    );

    for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
        logic sel_b;
        assign sel_b = reg_wr && dec.hit && (dec.bank == BSEL_W'(b));

        intc_bank #(
            .W        (BANK_W),
            .LVL_MASK (level_mask(b))
        ) u_bank (
            .clk      (clk),
            .rst      (rst),
            .live_i   (live_all[b*BANK_W +: BANK_W]),
            .rise_i   (rise_all[b*BANK_W +: BANK_W]),
            .en_wr_i  (sel_b && dec.sel == RG_EN),
            .ack_wr_i (sel_b && dec.sel == RG_ACK),
            .wdata_i  (reg_wdata[BANK_W-1:0]),
            .evt_o    (evt_all[b*BANK_W +: BANK_W]),
            .en_o     (en_all[b*BANK_W +: BANK_W]),
            .pend_o   (pend_all[b*BANK_W +: BANK_W])
        );
    end

    always_comb begin
        reg_rdata = '0;
        for (int b = 0; b < N_BANKS; b++) begin
            if (dec.hit && dec.bank == BSEL_W'(b)) begin
                unique case (dec.sel)
                    RG_EVT:  reg_rdata = DATA_W'(evt_all[b*BANK_W +: BANK_W]);
                    RG_EN:   reg_rdata = DATA_W'(en_all[b*BANK_W +: BANK_W]);
                    RG_ACK:  reg_rdata = '0;
                    RG_LVL:  reg_rdata = DATA_W'(live_all[b*BANK_W +: BANK_W]);
                    default: reg_rdata = '0;
                endcase
            end
        end
    end

    intc_prio #(.W(BANK_W), .NB(N_BANKS)) u_prio (
        .clk    (clk),
        .rst    (rst),
        .pend_i (pend_all),
        .out_o  (prio_q)
    );

    assign irq_o     = prio_q.irq;
    assign irq_vld_o = prio_q.vld;
    assign irq_idx_o = prio_q.idx;

    // R7
    irq_follows_pend_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> irq_o == $past(|pend_all));

    // R8
    idx_is_pending_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> !irq_vld_o || (($past(pend_all) >> irq_idx_o) & SRC_W'(1)) != '0);

    // R8
    idx_is_highest_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> !irq_vld_o || ($past(pend_all) >> irq_idx_o) == SRC_W'(1));

    // R8
    vld_matches_irq_chk: assert property (@(posedge clk) disable iff (rst)
        irq_vld_o == irq_o);

    // R11
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> !irq_o && !irq_vld_o && en_all == '0 && evt_all == '0);

endmodule

// File: tb/sim_irq_bank_ctrl.sv
`timescale 1ns/1ps
module sim_irq_bank_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    localparam logic [2:0] OP_WR  = 3'd0;
    localparam logic [2:0] OP_RD  = 3'd1;
    localparam logic [2:0] OP_SRC = 3'd2;
    localparam logic [2:0] OP_CK  = 3'd3;

    // {req, op, addr, data, expected}; CK expected = {irq, vld, idx[5:0]}
    localparam int NV = 41;
    localparam logic [142:0] VEC [NV] = '{
        {4'd11, OP_RD,  8'h24, 64'h0, 64'h0},                 // R11 enable clear
        {4'd11, OP_CK,  8'h00, 64'h0, 64'h0},                 // R11 outputs idle
        {4'd2,  OP_SRC, 8'h00, 64'h8, 64'h0},
        {4'd2,  OP_RD,  8'h20, 64'h0, 64'h8},                 // R2 latched while disabled
        {4'd7,  OP_CK,  8'h00, 64'h0, 64'h0},                 // R7 disabled -> no irq
        {4'd4,  OP_WR,  8'h24, 64'h8, 64'h0},
        {4'd8,  OP_CK,  8'h00, 64'h0, 64'hC3},                // R8 idx 3
        {4'd4,  OP_RD,  8'h24, 64'h0, 64'h8},                 // R4 readback
        {4'd3,  OP_WR,  8'h28, 64'h8, 64'h0},
        {4'd3,  OP_CK,  8'h00, 64'h0, 64'h0},                 // R3 ack drops irq
        {4'd3,  OP_RD,  8'h20, 64'h0, 64'h0},                 // R3 event cleared
        {4'd2,  OP_SRC, 8'h00, 64'h0, 64'h0},
        {4'd2,  OP_SRC, 8'h00, 64'h18, 64'h0},
        {4'd2,  OP_RD,  8'h20, 64'h0, 64'h18},                // R2 two edges
        {4'd3,  OP_WR,  8'h28, 64'h10, 64'h0},
        {4'd3,  OP_RD,  8'h20, 64'h0, 64'h08},                // R3 zero bits untouched
        {4'd3,  OP_RD,  8'h28, 64'h0, 64'h0},                 // R3 ack reads zero
        {4'd5,  OP_WR,  8'h24, 64'h18, 64'h0},
        {4'd5,  OP_RD,  8'h20, 64'h0, 64'h08},                // R5 no event from enable
        {4'd5,  OP_CK,  8'h00, 64'h0, 64'hC3},                // R5 still idx 3
        {4'd6,  OP_SRC, 8'h00, 64'h0200_0018, 64'h0},
        {4'd6,  OP_RD,  8'h2C, 64'h0, 64'h0200_0018},         // R6 live word
        {4'd6,  OP_RD,  8'h20, 64'h0, 64'h08},                // R6 level bit no event
        {4'd6,  OP_WR,  8'h24, 64'h0200_0018, 64'h0},
        {4'd6,  OP_CK,  8'h00, 64'h0, 64'hD9},                // R6 idx 25
        {4'd6,  OP_SRC, 8'h00, 64'h18, 64'h0},
        {4'd6,  OP_CK,  8'h00, 64'h0, 64'hC3},                // R6 level not held
        {4'd1,  OP_SRC, 8'h00, 64'h0000_0100_0200_0018, 64'h0},
        {4'd1,  OP_RD,  8'h10, 64'h0, 64'h100},               // R1 upper event at 0x10
        {4'd1,  OP_RD,  8'h1C, 64'h0, 64'h100},               // R1 upper live at 0x1C
        {4'd7,  OP_CK,  8'h00, 64'h0, 64'hD9},                // R7 upper disabled
        {4'd1,  OP_WR,  8'h14, 64'h100, 64'h0},
        {4'd8,  OP_CK,  8'h00, 64'h0, 64'hE8},                // R8 upper wins, idx 40
        {4'd10, OP_WR,  8'h10, 64'h0, 64'h0},
        {4'd10, OP_RD,  8'h10, 64'h0, 64'h100},               // R10 event write ignored
        {4'd1,  OP_RD,  8'h14, 64'h0, 64'h100},               // R1 upper enable
        {4'd1,  OP_WR,  8'h30, 64'hFFFF_FFFF, 64'h0},
        {4'd1,  OP_RD,  8'h30, 64'h0, 64'h0},                 // R1 unmapped
        {4'd3,  OP_WR,  8'h18, 64'h100, 64'h0},
        {4'd8,  OP_CK,  8'h00, 64'h0, 64'hD9},                // R8 back to idx 25
        {4'd7,  OP_CK,  8'h00, 64'h0, 64'hD9}                 // R7 steady
    };

    logic        clk = 1'b0;
    logic        rst;
    logic [63:0] src;
    logic [5:0]  addr;
    logic        wr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        irq;
    logic        vld;
    logic [5:0]  idx;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_bank_ctrl u0 (
        .clk       (clk),
        .rst       (rst),
        .src_i     (src),
        .reg_addr  (addr),
        .reg_wr    (wr),
        .reg_wdata (wdata),
        .reg_rdata (rdata),
        .irq_o     (irq),
        .irq_vld_o (vld),
        .irq_idx_o (idx)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic [5:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic do_rd(input logic [5:0] a, input logic [31:0] e, input string req);
        addr = a;
        #1;
        check(req, 64'(rdata), 64'(e));
    endtask

    task automatic do_ck(input logic [7:0] e, input string req);
        repeat (2) @(negedge clk);
        check(req, 64'({irq, vld, idx}), 64'(e));
    endtask

    task automatic do_src(input logic [63:0] v);
        src = v;
        repeat (5) @(negedge clk);
    endtask

    initial begin
        rst = 1'b1; src = '0; addr = '0; wr = 1'b0; wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            logic [3:0]  rq;
            logic [2:0]  op;
            logic [7:0]  a;
            logic [63:0] d;
            logic [63:0] e;
            string       tag;
            {rq, op, a, d, e} = VEC[i];
            tag = $sformatf("R%0d vec%0d", rq, i);
            case (op)
                OP_WR:   do_wr(a[5:0], d[31:0]);
                OP_RD:   do_rd(a[5:0], e[31:0], tag);
                OP_SRC:  do_src(d);
                default: do_ck(e[7:0], tag);
            endcase
        end

        // R9: edge and ack of bit 5 meet at the same clock edge
        do_wr(6'h14, 32'h0);
        do_src(64'h18 | 64'h20);
        do_src(64'h18);
        do_rd(6'h20, 32'h28, "R9 pre");
        src = 64'h18 | 64'h20;                 // rise seen at third edge
        @(negedge clk);
        @(negedge clk);
        do_wr(6'h28, 32'h20);                  // captured at that third edge
        do_rd(6'h20, 32'h28, "R9 set wins");
        do_wr(6'h28, 32'h28);
        do_rd(6'h20, 32'h0, "R9 plain ack clears");

        // R11: reset mid-run
        do_src(64'h0);
        do_wr(6'h24, 32'hFFFF_FFFF);
        do_src(64'h4);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        do_rd(6'h24, 32'h0, "R11 enable after reset");
        do_rd(6'h20, 32'h0, "R11 event after reset");
        check("R11 irq after reset", 64'({irq, vld}), 64'h0);
        do_ck(8'h00, "R11 idle after reset");

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule